// File: doc/BRIEF.md
# Serial-Flash Host Data FIFO and Interrupt Unit

This block is the host-facing data and status unit of a serial-flash controller. Software moves payload through one 32-bit data port. A write to the port pushes a word into a transmit FIFO, and a read pops a word from a receive FIFO. A final partial word of 1 to 3 bytes is carried in the lowest byte lanes in little-endian order, so the block itself only ever moves whole words. The serial engine sits on the other side. It sees only a pop/data/valid port for transmit and a push/data/ready port for receive, plus four event strobes.

The unit packs both FIFO levels and their full and empty flags into one status register. The transmit level counts free words and the receive level counts filled words. Eight sticky interrupt sources are gathered into a raw register. That register has write-one-to-clear, a mask, a masked view and a single interrupt line. A self-clearing soft-reset bit empties both FIFOs and wipes the raw interrupts over a fixed number of cycles.

Register word addresses: 0 data port, 1 FIFO status, 2 raw interrupts, 3 mask, 4 clear (reads zero), 5 masked interrupts, 6 soft reset.

Top module: `flash_fifo_irq`

## Requirements
- R1: After reset the status register reads 0x0000_1006, and the raw register reads 0. The mask reads 0xFF, the reset register reads 0 and irq is low. Status fields are: bit 0 transmit full, bit 1 transmit empty, bit 2 receive empty, bit 3 receive full, bits [12:8] free transmit words, bits [20:16] filled receive words.
- R2: Words written to the data port leave the transmit side (eng_tx_data with eng_tx_valid) in the order written. The free level falls by one per word.
- R3: A data-port write while the transmit FIFO holds 16 words is dropped, and it sets raw bit 2 (transmit overflow).
- R4: Words pushed by the engine are returned by data-port reads in push order. The receive level counts them.
- R5: A data-port read with an empty receive FIFO returns 0 and sets raw bit 1 (receive underflow).
- R6: Raw bit 3 sets when the transmit FIFO drains to empty. Raw bit 0 sets when the receive FIFO fills to 16, and eng_rx_ready is then low.
- R7: The event inputs set raw bits 4 (transfer done), 5 (bus error), 6 (serial error) and 7 (DMA done). Each bit is sticky.
- R8: Writing the clear register clears exactly the raw bits written as 1. A source that sets a bit in the same cycle keeps it set.
- R9: The masked register is raw AND NOT mask, where a mask bit of 1 disables that source. irq is high exactly when the masked register is non-zero.
- R10: Writing 1 to bit 0 of the reset register makes that bit read 1 for exactly 4 cycles and then 0. Afterwards both FIFOs are empty and the raw register is 0, and data-port writes during those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data port) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | 32 | Transmit head word |
| eng_tx_valid | output | 1 | Transmit FIFO holds a word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_ready | output | 1 | Receive FIFO has room |
| evt_xfer_done | input | 1 | Transfer finished strobe |
| evt_bus_err | input | 1 | Bus error strobe |
| evt_serial_err | input | 1 | Serial error strobe |
| evt_dma_done | input | 1 | DMA finished strobe |
| srst_busy | output | 1 | Soft reset in progress |
| irq | output | 1 | OR of the masked interrupts |

## Verification
The bench builds the block with its defaults: 16-word FIFOs and a 4-cycle soft reset. With those values, filling either FIFO completely takes only a few dozen cycles, so the full flags, the overflow drop and the receive-full event are all reached. The status words also have exact expected values, such as a free level of 16. The short reset window lets the bench step through each busy cycle and slip an ignored data write into the middle of it.

// File: rtl/flash_fifo_irq.sv
module flash_fifo_irq #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int SRST_CYC = 4,
  parameter int AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  output logic          eng_rx_ready,
  input  logic          evt_xfer_done,
  input  logic          evt_bus_err,
  input  logic          evt_serial_err,
  input  logic          evt_dma_done,
  output logic          srst_busy,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(SRST_CYC + 1);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_RAW  = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);
  localparam logic [AW-1:0] A_MSKD = AW'(5);
  localparam logic [AW-1:0] A_RST  = AW'(6);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt, tx_cnt_nxt, rx_cnt_nxt;
  logic [CW-1:0] srst_cnt;
  logic [7:0]    raw, mask, set_v, clr_v;
  logic          busy;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          host_wd, host_rd, tx_push, tx_ovf, tx_pop, rx_push, rx_pop, rx_unf;
  logic [DW-1:0] status;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy      = srst_cnt != '0;
  assign srst_busy = busy;
  assign tx_full   = tx_cnt == LW'(DEPTH);
  assign tx_empty  = tx_cnt == '0;
  assign rx_full   = rx_cnt == LW'(DEPTH);
  assign rx_empty  = rx_cnt == '0;

  assign host_wd = reg_wr && reg_addr == A_DATA && !busy;
  assign host_rd = reg_rd && reg_addr == A_DATA && !busy;
  assign tx_push = host_wd && !tx_full;
  assign tx_ovf  = host_wd && tx_full;
  assign tx_pop  = eng_tx_pop && !tx_empty && !busy;
  assign rx_push = eng_rx_push && !rx_full && !busy;
  assign rx_pop  = host_rd && !rx_empty;
  assign rx_unf  = host_rd && rx_empty;

  assign tx_cnt_nxt = busy ? '0 : tx_cnt + LW'(tx_push) - LW'(tx_pop);
  assign rx_cnt_nxt = busy ? '0 : rx_cnt + LW'(rx_push) - LW'(rx_pop);

  assign eng_tx_data  = tx_mem[tx_rp];
  assign eng_tx_valid = !tx_empty && !busy;
  assign eng_rx_ready = !rx_full && !busy;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (busy) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      tx_cnt <= tx_cnt_nxt;
      rx_cnt <= rx_cnt_nxt;
    end
  end

  assign set_v = {evt_dma_done && !busy, evt_serial_err && !busy,
                  evt_bus_err && !busy, evt_xfer_done && !busy,
                  !tx_empty && tx_cnt_nxt == '0, tx_ovf, rx_unf,
                  !rx_full && rx_cnt_nxt == LW'(DEPTH)};
  assign clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw      <= '0;
      mask     <= 8'hFF;
      srst_cnt <= '0;
    end else begin
      raw <= busy ? 8'h00 : ((raw & ~clr_v) | set_v);
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[7:0];
      if (busy) srst_cnt <= srst_cnt - 1'b1;
      else if (reg_wr && reg_addr == A_RST && reg_wdata[0]) srst_cnt <= CW'(SRST_CYC);
    end
  end

  assign irq = |(raw & ~mask);

  always_comb begin
    status = '0;
    status[0] = tx_full;
    status[1] = tx_empty;
    status[2] = rx_empty;
    status[3] = rx_full;
    status[8 +: LW]  = LW'(DEPTH) - tx_cnt;
    status[16 +: LW] = rx_cnt;
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_empty ? '0 : rx_mem[rx_rp];
      A_STAT:  reg_rdata = status;
      A_RAW:   reg_rdata = DW'(raw);
      A_MASK:  reg_rdata = DW'(mask);
      A_MSKD:  reg_rdata = DW'(raw & ~mask);
      A_RST:   reg_rdata = DW'(busy);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module flash_fifo_irq_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 3,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          eng_tx_pop,
  input logic          evt_xfer_done,
  input logic          busy,
  input logic [LW-1:0] tx_cnt,
  input logic [LW-1:0] rx_cnt,
  input logic [7:0]    raw,
  input logic [7:0]    mask,
  input logic          irq
);
  AST_TX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && !busy && tx_cnt == LW'(DEPTH)) |=> raw[2]); // R3
  AST_TX_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && !busy && tx_cnt == LW'(DEPTH) && !eng_tx_pop) |=> tx_cnt == LW'(DEPTH)); // R3
  AST_RX_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == '0 && rx_cnt == '0) |-> reg_rdata == '0); // R5
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_xfer_done && !busy) |=> raw[4]); // R7
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'hFF) |-> !irq); // R9
  AST_SRST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (raw == 8'h00 && tx_cnt == '0 && rx_cnt == '0)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eng_tx_pop && !(reg_wr && reg_addr == '0)) |=> $stable(tx_cnt)); // R2
endmodule

bind flash_fifo_irq flash_fifo_irq_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop), .evt_xfer_done(evt_xfer_done),
  .busy(busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .raw(raw), .mask(mask), .irq(irq)
);

// File: tb/sim_flash_fifo_irq.sv
module sim_flash_fifo_irq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_tx_pop = 0, eng_tx_valid, eng_rx_push = 0, eng_rx_ready;
  logic [31:0] eng_tx_data, eng_rx_data = '0;
  logic evt_xfer_done = 0, evt_bus_err = 0, evt_serial_err = 0, evt_dma_done = 0;
  logic srst_busy, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_fifo_irq u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #4 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic tx_take(output logic [31:0] d, output logic v);
    eng_tx_pop = 1;
    #4 d = eng_tx_data; v = eng_tx_valid;
    @(negedge clk);
    eng_tx_pop = 0;
  endtask

  task automatic rx_give(input logic [31:0] d);
    eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1, v); chk("R1 status", v, 32'h0000_1006);
    rd(2, v); chk("R1 raw", v, 0);
    rd(3, v); chk("R1 mask", v, 32'hFF);
    rd(6, v); chk("R1 reset reg", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx_order;
    logic [31:0] v; logic ok;
    wr(0, 32'hA1); wr(0, 32'hB2); wr(0, 32'h00C3_0201);
    rd(1, v); chk("R2 status three words", v, 32'h0000_0D04);
    tx_take(v, ok); chk("R2 first", v, 32'hA1); chk("R2 valid", ok, 1);
    tx_take(v, ok); chk("R2 second", v, 32'hB2);
    tx_take(v, ok); chk("R2 third partial word", v, 32'h00C3_0201);
    chk("R6 tx drained valid low", eng_tx_valid, 0);
    rd(2, v); chk("R6 tx empty event", v, 32'h08);
    wr(4, 32'h08);
    rd(2, v); chk("R8 clear tx empty", v, 0);
  endtask

  task automatic t_tx_full;
    logic [31:0] v; logic ok;
    for (int i = 0; i < 16; i++) wr(0, 32'h100 + i);
    rd(1, v); chk("R3 status full", v, 32'h0000_0005);
    wr(0, 32'hDEAD_BEEF);
    rd(2, v); chk("R3 overflow bit", v, 32'h04);
    rd(1, v); chk("R3 still full after drop", v, 32'h0000_0005);
    for (int i = 0; i < 16; i++) begin
      tx_take(v, ok); chk("R3 stored word", v, 32'h100 + i);
    end
    chk("R3 dropped word absent", eng_tx_valid, 0);
    rd(2, v); chk("R6 overflow plus empty", v, 32'h0C);
    wr(4, 32'hFF);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    rx_give(32'h1111_0000); rx_give(32'h0000_2222);
    rd(1, v); chk("R4 status two words", v, 32'h0002_1002);
    rd(0, v); chk("R4 first", v, 32'h1111_0000);
    rd(0, v); chk("R4 second", v, 32'h0000_2222);
    rd(2, v); chk("R5 no underflow yet", v, 0);
    rd(0, v); chk("R5 empty read zero", v, 0);
    rd(2, v); chk("R5 underflow bit", v, 32'h02);
    wr(4, 32'hFF);
  endtask

  task automatic t_rx_full;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) rx_give(32'h200 + i);
    rd(1, v); chk("R6 rx full status", v, 32'h0010_100A);
    chk("R6 rx ready low", eng_rx_ready, 0);
    rd(2, v); chk("R6 rx full event", v, 32'h01);
    rx_give(32'hBAD);
    for (int i = 0; i < 16; i++) begin
      rd(0, v); chk("R6 rx drain order", v, 32'h200 + i);
    end
    rd(1, v); chk("R6 rx extra push ignored", v, 32'h0000_1006);
    wr(4, 32'hFF);
  endtask

  task automatic t_events_mask;
    logic [31:0] v;
    evt_xfer_done = 1; @(negedge clk); evt_xfer_done = 0;
    evt_bus_err = 1; @(negedge clk); evt_bus_err = 0;
    evt_serial_err = 1; @(negedge clk); evt_serial_err = 0;
    evt_dma_done = 1; @(negedge clk); evt_dma_done = 0;
    repeat (2) @(negedge clk);
    rd(2, v); chk("R7 sticky events", v, 32'hF0);
    wr(4, 32'h30);
    rd(2, v); chk("R8 partial clear", v, 32'hC0);
    evt_serial_err = 1; wr(4, 32'h40); evt_serial_err = 0;
    rd(2, v); chk("R8 set wins over clear", v, 32'hC0);
    chk("R9 all masked irq", irq, 0);
    rd(5, v); chk("R9 masked none", v, 0);
    wr(3, 32'h7F);
    rd(5, v); chk("R9 masked view", v, 32'h80);
    chk("R9 irq high", irq, 1);
    wr(4, 32'h80);
    chk("R9 irq low after clear", irq, 0);
    wr(3, 32'hFF); wr(4, 32'hFF);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(0, 32'h5); wr(0, 32'h6); rx_give(32'h7);
    evt_bus_err = 1; @(negedge clk); evt_bus_err = 0;
    wr(6, 32'h1);
    rd(6, v); chk("R10 busy cycle 1", v, 1);
    wr(0, 32'h99);
    rd(6, v); chk("R10 busy cycle 3", v, 1);
    rd(6, v); chk("R10 busy cycle 4", v, 1);
    rd(6, v); chk("R10 self clear", v, 0);
    rd(1, v); chk("R10 fifos empty, write ignored", v, 32'h0000_1006);
    rd(2, v); chk("R10 raw wiped", v, 0);
    chk("R10 tx valid low", eng_tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_rx_full();
    t_events_mask();
    t_srst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule